// File: doc/BRIEF.md
# Accumulator Machine Control Sequencer

This block is the hardwired control unit and datapath of a 16-bit stored-program machine with a single accumulator. It holds a 12-bit address register and program counter, plus a data register, an instruction register, the accumulator and a carry/link flag. A free-running step counter selects one timing state per clock. Each instruction passes through a fixed run of states: fetch, decode, an optional pointer read, then execute. The counter returns to zero at a state that depends on the opcode. Memory-reference instructions are AND, ADD, LDA, STA, BUN, BSA and ISZ, and any of them may use indirect addressing. Register-reference instructions act on the accumulator and the flag, or skip the next word conditionally, or halt.

The block drives a synchronous 4096-word memory through one address port, a read strobe, a write strobe and write data. Read data must be valid in the same cycle the read strobe is high, so the port has no handshake and no back-pressure. A transfer is never stalled, and the memory must accept a write on every cycle its write strobe is high. After HLT the `halted` output stays high and no memory strobe is issued until reset.

Top module: `acc_sequencer`

## Requirements
- R1: While reset is low, both memory strobes and `halted` are low. Reset clears the PC, step counter, flag E and stop state. In the first cycle after reset the read strobe is low. In the second cycle the read strobe is high with address 0.
- R2: An instruction word keeps the indirect flag in bit 15, the opcode in bits 14..12 and the address in bits 11..0. Opcode codes are AND=0, ADD=1, LDA=2, STA=3, BUN=4, BSA=5, ISZ=6 and 7=register/IO space. Each fetch increments the PC by one. Read and write strobes are never high together.
- R3: For opcodes 0..6 with bit 15 set, the word at the address field is read in the fourth cycle. Its low 12 bits become the operand address, and its upper bits are ignored. This read adds no cycle.
- R4: AND, ADD and LDA take 6 cycles. They leave AC = AC&M, AC+M (low 16 bits) or M respectively. ADD puts its carry-out in E, while AND and LDA leave E unchanged.
- R5: STA writes AC to the operand address and takes 5 cycles. BUN continues at the operand address and takes 5 cycles.
- R6: BSA takes 6 cycles. It stores the return address (the address after the BSA word, zero-extended) at the operand address and continues at operand address + 1.
- R7: ISZ takes 7 cycles. It writes M+1 back to the operand address and skips the next word when that sum is zero. The step counter never exceeds 6.
- R8: Register words 7800 (clear AC), 7400 (clear E), 7200 (invert AC), 7100 (invert E) and 7020 (AC+1, E unchanged) take 4 cycles each.
- R9: 7080 rotates E and AC right as one 17-bit ring, with AC bit 0 going to E. 7040 rotates them left, with AC bit 15 going to E. Each takes 4 cycles.
- R10: Word 7010 skips when AC bit 15 is 0. Word 7008 skips when it is 1. Word 7004 skips when AC is zero, and 7002 skips when E is 0. A skip bypasses the next word.
- R11: Word 7001 raises `halted` after its 4 cycles. `halted` then stays high with both strobes low until reset.
- R12: If a register word has more than one of bits 11..0 set, only the highest-numbered set bit takes effect.
- R13: A word with bits 15..12 = 1111 completes in 4 cycles and changes neither AC, E nor the flow of the program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Memory word address (the address register) |
| mem_rd | output | 1 | Read strobe; data returns in the same cycle |
| mem_wr | output | 1 | Write strobe; word written at the rising edge |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid while mem_rd is high |
| halted | output | 1 | High after a halt word until reset |

## Verification
On every cycle the assertions check these properties. Read and write strobes never coincide. The halted state is sticky and silent on the memory port. The address register takes the PC after the first state, and the PC steps once per fetch. The opcode decode is one-hot. The step counter never passes the last ISZ state, and it is zero once stopped. Increment leaves E alone. The bench scenarios show everything that needs data values or the program flow. This covers the arithmetic and carry results, the rotate rings, the skip decisions over sign, zero and flag patterns, the return address written by BSA, the priority among combined register bits, and the exact cycle cost of every instruction class.

// File: rtl/acc_pkg.sv
package acc_pkg;

  // Memory-reference opcodes; the decoder output is indexed by these codes.
  typedef enum logic [2:0] {
    OP_AND = 3'd0,
    OP_ADD = 3'd1,
    OP_LDA = 3'd2,
    OP_STA = 3'd3,
    OP_BUN = 3'd4,
    OP_BSA = 3'd5,
    OP_ISZ = 3'd6,
    OP_REG = 3'd7
  } opcode_e;

  // Bit positions inside the address field of a register word.
  localparam int REG_BITS = 12;
  localparam int RB_CLA = 11;
  localparam int RB_CLE = 10;
  localparam int RB_CMA = 9;
  localparam int RB_CME = 8;
  localparam int RB_CIR = 7;
  localparam int RB_CIL = 6;
  localparam int RB_INC = 5;
  localparam int RB_SPA = 4;
  localparam int RB_SNA = 3;
  localparam int RB_SZA = 2;
  localparam int RB_SZE = 1;
  localparam int RB_HLT = 0;

  typedef enum logic [3:0] {
    AC_HOLD, AC_AND, AC_ADD, AC_LOAD, AC_CLR, AC_CMP, AC_ROR, AC_ROL, AC_INC
  } ac_op_e;

  typedef enum logic [2:0] {
    E_HOLD, E_CARRY, E_CLR, E_CMP, E_LSB, E_MSB
  } e_op_e;

  typedef struct packed {
    ac_op_e ac_op;
    e_op_e  e_op;
    logic   skip;
    logic   halt;
  } regop_t;

endpackage

// File: rtl/acc_timing.sv
module acc_timing #(
  parameter int unsigned SC_W = 4,
  parameter int unsigned N_T  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            stop,
  output logic [SC_W-1:0] sc,
  output logic [N_T-1:0]  t
);

  localparam logic [SC_W-1:0] ONE = SC_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sc <= '0;
    else if (clr || stop) sc <= '0;
    else                  sc <= sc + ONE;
  end

  // One timing strobe per decoded state; all strobes are dead once stopped.
  for (genvar k = 0; k < N_T; k++) begin : g_state
    assign t[k] = !stop && (sc == SC_W'(k));
  end

  p_stop_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (sc == '0));

endmodule

// File: rtl/acc_opdec.sv
module acc_opdec #(
  parameter int unsigned OPC_W = 3,
  parameter int unsigned N_D   = 1 << OPC_W
) (
  input  logic [OPC_W-1:0] opc,
  output logic [N_D-1:0]   d
);

  for (genvar k = 0; k < N_D; k++) begin : g_line
    assign d[k] = (opc == OPC_W'(k));
  end

endmodule

// File: rtl/acc_regop.sv
module acc_regop
  import acc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [REG_BITS-1:0] sel,
  input  logic [W-1:0]        ac,
  input  logic                e,
  output regop_t              cmd
);

  logic [3:0] top_bit;
  logic       any_bit;

  // Highest-numbered set bit wins when several are set.
  always_comb begin
    top_bit = '0;
    any_bit = 1'b0;
    for (int b = 0; b < REG_BITS; b++) begin
      if (sel[b]) begin
        top_bit = 4'(b);
        any_bit = 1'b1;
      end
    end
  end

  always_comb begin
    cmd.ac_op = AC_HOLD;
    cmd.e_op  = E_HOLD;
    cmd.skip  = 1'b0;
    cmd.halt  = 1'b0;
    if (any_bit) begin
      case (top_bit)
        4'(RB_CLA): cmd.ac_op = AC_CLR;
        4'(RB_CLE): cmd.e_op  = E_CLR;
        4'(RB_CMA): cmd.ac_op = AC_CMP;
        4'(RB_CME): cmd.e_op  = E_CMP;
        4'(RB_CIR): begin cmd.ac_op = AC_ROR; cmd.e_op = E_LSB; end
        4'(RB_CIL): begin cmd.ac_op = AC_ROL; cmd.e_op = E_MSB; end
        4'(RB_INC): cmd.ac_op = AC_INC;
        4'(RB_SPA): cmd.skip  = !ac[W-1];
        4'(RB_SNA): cmd.skip  = ac[W-1];
        4'(RB_SZA): cmd.skip  = (ac == '0);
        4'(RB_SZE): cmd.skip  = !e;
        4'(RB_HLT): cmd.halt  = 1'b1;
        default:    cmd.halt  = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  ac_op_e       op,
  input  e_op_e        eop,
  input  logic [W-1:0] ac,
  input  logic [W-1:0] dr,
  input  logic         e,
  output logic [W-1:0] ac_nxt,
  output logic         e_nxt
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W:0] sum;
  assign sum = {1'b0, ac} + {1'b0, dr};

  always_comb begin
    case (op)
      AC_AND:  ac_nxt = ac & dr;
      AC_ADD:  ac_nxt = sum[W-1:0];
      AC_LOAD: ac_nxt = dr;
      AC_CLR:  ac_nxt = '0;
      AC_CMP:  ac_nxt = ~ac;
      AC_ROR:  ac_nxt = {e, ac[W-1:1]};
      AC_ROL:  ac_nxt = {ac[W-2:0], e};
      AC_INC:  ac_nxt = ac + ONE;
      default: ac_nxt = ac;
    endcase
  end

  always_comb begin
    case (eop)
      E_CARRY: e_nxt = sum[W];
      E_CLR:   e_nxt = 1'b0;
      E_CMP:   e_nxt = !e;
      E_LSB:   e_nxt = ac[0];
      E_MSB:   e_nxt = ac[W-1];
      default: e_nxt = e;
    endcase
  end

endmodule

// File: rtl/acc_sequencer.sv
module acc_sequencer
  import acc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SC_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);

  // Word layout: indirect flag on top, opcode below it, address field at the bottom.
  localparam int unsigned OPC_W  = 3;
  localparam int unsigned N_D    = 1 << OPC_W;
  localparam int unsigned N_T    = 7;   // states T0..T6 are ever reached
  localparam int unsigned IND_B  = DATA_W - 1;
  localparam int unsigned OPC_HI = DATA_W - 2;
  localparam int unsigned PAD_W  = DATA_W - ADDR_W;
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
  localparam logic [DATA_W-1:0] ONE_D = DATA_W'(1);

  logic [ADDR_W-1:0] ar, pc;
  logic [DATA_W-1:0] dr, ac, ir;
  logic              e, ind, stop;

  logic [SC_W-1:0] sc;
  logic [N_T-1:0]  t;
  logic [N_D-1:0]  d;
  logic            sc_clr;

  regop_t cmd;
  ac_op_e ac_sel;
  e_op_e  e_sel;
  logic [DATA_W-1:0] ac_nxt;
  logic              e_nxt;

  logic rr, io, ind_rd, op_rd, wr_sta, wr_bsa, wr_isz;
  logic pc_skip, pc_jump, halt_set, isz_zero;

  acc_timing #(.SC_W(SC_W), .N_T(N_T)) u_timing (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (sc_clr),
    .stop (stop),
    .sc   (sc),
    .t    (t)
  );

  acc_opdec #(.OPC_W(OPC_W), .N_D(N_D)) u_opdec (
    .opc(ir[OPC_HI -: OPC_W]),
    .d  (d)
  );

  acc_regop #(.W(DATA_W)) u_regop (
    .sel(ir[REG_BITS-1:0]),
    .ac (ac),
    .e  (e),
    .cmd(cmd)
  );

  acc_alu #(.W(DATA_W)) u_alu (
    .op    (ac_sel),
    .eop   (e_sel),
    .ac    (ac),
    .dr    (dr),
    .e     (e),
    .ac_nxt(ac_nxt),
    .e_nxt (e_nxt)
  );

  // Control functions of timing state and decoded opcode.
  always_comb begin
    rr       = t[3] && d[OP_REG] && !ind;
    io       = t[3] && d[OP_REG] && ind;
    ind_rd   = t[3] && !d[OP_REG] && ind;
    op_rd    = t[4] && (d[OP_AND] || d[OP_ADD] || d[OP_LDA] || d[OP_ISZ]);
    wr_sta   = t[4] && d[OP_STA];
    wr_bsa   = t[4] && d[OP_BSA];
    wr_isz   = t[6] && d[OP_ISZ];
    isz_zero = (dr == '0);
    pc_skip  = (rr && cmd.skip) || (wr_isz && isz_zero);
    pc_jump  = (t[4] && d[OP_BUN]) || (t[5] && d[OP_BSA]);
    halt_set = rr && cmd.halt;
    sc_clr   = rr || io
            || (t[4] && (d[OP_STA] || d[OP_BUN]))
            || (t[5] && (d[OP_AND] || d[OP_ADD] || d[OP_LDA] || d[OP_BSA]))
            || wr_isz;
  end

  always_comb begin
    ac_sel = AC_HOLD;
    e_sel  = E_HOLD;
    if (t[5] && d[OP_AND]) ac_sel = AC_AND;
    if (t[5] && d[OP_ADD]) begin
      ac_sel = AC_ADD;
      e_sel  = E_CARRY;
    end
    if (t[5] && d[OP_LDA]) ac_sel = AC_LOAD;
    if (rr) begin
      ac_sel = cmd.ac_op;
      e_sel  = cmd.e_op;
    end
  end

  // Memory port: the address register addresses memory directly.
  always_comb begin
    mem_addr = ar;
    mem_rd   = t[1] || ind_rd || op_rd;
    mem_wr   = wr_sta || wr_bsa || wr_isz;
    if (wr_sta)      mem_wdata = ac;
    else if (wr_bsa) mem_wdata = {{PAD_W{1'b0}}, pc};
    else             mem_wdata = dr;
  end

  assign halted = stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar <= '0;
      pc <= '0;
    end else begin
      if (t[0])        ar <= pc;
      else if (t[2])   ar <= ir[ADDR_W-1:0];
      else if (ind_rd) ar <= mem_rdata[ADDR_W-1:0];
      else if (wr_bsa) ar <= ar + ONE_A;

      if (t[1] || pc_skip) pc <= pc + ONE_A;
      else if (pc_jump)    pc <= ar;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir  <= '0;
      ind <= 1'b0;
      dr  <= '0;
    end else begin
      if (t[1]) ir <= mem_rdata;
      if (t[2]) ind <= ir[IND_B];
      if (op_rd)                   dr <= mem_rdata;
      else if (t[5] && d[OP_ISZ])  dr <= dr + ONE_D;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac   <= '0;
      e    <= 1'b0;
      stop <= 1'b0;
    end else begin
      ac <= ac_nxt;
      e  <= e_nxt;
      if (halt_set) stop <= 1'b1;
    end
  end

  // ---------------- assertions ----------------
  p_rw_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_ar_from_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    t[0] |=> (ar == $past(pc)));

  p_fetch_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    t[1] |=> (pc == $past(pc) + ONE_A));

  p_dec_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(d) == 1);

  p_sc_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sc <= SC_W'(6));

  p_isz_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && d[OP_ISZ]) |=> (sc == '0));

  p_inc_keeps_e_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rr && ir[REG_BITS-1:0] == 12'h020) |=> (e == $past(e)));

  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));

endmodule

// File: tb/acc_sequencer_tb.sv
`timescale 1ns/1ps
module acc_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        halted;
  logic [15:0] mem [0:4095];

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  acc_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted)
  );

  localparam logic [15:0] W_CLA = 16'h7800, W_CLE = 16'h7400, W_CMA = 16'h7200,
                          W_CME = 16'h7100, W_CIR = 16'h7080, W_CIL = 16'h7040,
                          W_INC = 16'h7020, W_SPA = 16'h7010, W_SNA = 16'h7008,
                          W_SZA = 16'h7004, W_SZE = 16'h7002, W_HLT = 16'h7001;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mri(int op, bit ind, int a);
    return {ind, 3'(op), 12'(a)};
  endfunction

  task automatic wipe();
    for (int k = 0; k < 128; k++) mem[k] = 16'h0000;
  endtask

  task automatic run(output int cyc);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 3000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    if (!halted) begin
      n_chk++; n_bad++;
      $display("FAIL R11 no halt: actual %0d cycles expected halt", cyc);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    int quiet_bad;
    wipe();
    mem[0] = W_HLT;
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state and first fetch
    chk("R1", "halted in reset", 32'(halted), 0);
    chk("R1", "rd in reset", 32'(mem_rd), 0);
    chk("R1", "wr in reset", 32'(mem_wr), 0);
    rst_n = 1'b1;
    chk("R1", "rd in first cycle", 32'(mem_rd), 0);
    @(posedge clk); @(negedge clk);
    chk("R1", "rd in second cycle", 32'(mem_rd), 1);
    chk("R1", "fetch address", 32'(mem_addr), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "halted after HLT", 32'(halted), 1);
    quiet_bad = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (mem_rd || mem_wr || !halted) quiet_bad++;
    end
    chk("R11", "strobes while halted", 32'(quiet_bad), 0);

    // R4: ADD sweep with carry into E
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [15:0] a, b;
        logic [16:0] s;
        a = 16'(i * 16'h1111 + j * 3);
        b = 16'(j * 16'h1111 ^ (i << 4));
        s = {1'b0, a} + {1'b0, b};
        wipe();
        mem[0] = mri(2, 0, 'h20); mem[1] = mri(1, 0, 'h21); mem[2] = mri(3, 0, 'h22);
        mem[3] = W_CLA; mem[4] = W_CIL; mem[5] = mri(3, 0, 'h23); mem[6] = W_HLT;
        mem['h20] = a; mem['h21] = b;
        run(cyc);
        chk("R4", "ADD sum", 32'(mem['h22]), 32'(s[15:0]));
        chk("R4", "ADD carry", 32'(mem['h23]), 32'(s[16]));
        chk("R4", "ADD cycles", 32'(cyc), 34);
      end
    end

    // R3 and R4: indirect LDA / AND, E kept
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [15:0] a, b;
        a = 16'hA5C3 ^ 16'(i * 16'h0841);
        b = 16'(16'h3CF0 + j * 16'h1357);
        wipe();
        mem[0] = W_CME; mem[1] = mri(2, 1, 'h30); mem[2] = mri(0, 1, 'h31);
        mem[3] = mri(3, 0, 'h22); mem[4] = W_CLA; mem[5] = W_CIL;
        mem[6] = mri(3, 0, 'h23); mem[7] = W_HLT;
        mem['h30] = 16'h7F40; mem['h31] = 16'h8F41;
        mem['hF40] = a; mem['hF41] = b;
        run(cyc);
        chk("R3", "indirect AND", 32'(mem['h22]), 32'(a & b));
        chk("R4", "E kept by LDA/AND", 32'(mem['h23]), 1);
        chk("R3", "indirect cycles", 32'(cyc), 38);
      end
    end

    // R5 and R6: BUN, BSA, STA, indirect return
    wipe();
    mem[0] = mri(4, 0, 'h10); mem[1] = W_HLT;
    mem['h10] = mri(5, 0, 'h40); mem['h11] = W_HLT;
    mem['h41] = mri(2, 0, 'h51); mem['h42] = mri(3, 0, 'h52); mem['h43] = mri(4, 1, 'h40);
    mem['h51] = 16'hBEEF;
    run(cyc);
    chk("R6", "BSA return slot", 32'(mem['h40]), 32'h0011);
    chk("R5", "STA data", 32'(mem['h52]), 32'hBEEF);
    chk("R5", "branch program cycles", 32'(cyc), 31);

    // R7: ISZ with and without skip
    for (int k = 0; k < 5; k++) begin
      logic [15:0] v, w;
      case (k)
        0: v = 16'hFFFF;
        1: v = 16'hFFFE;
        2: v = 16'h0000;
        3: v = 16'h1234;
        default: v = 16'h7FFF;
      endcase
      w = v + 16'h0001;
      wipe();
      mem[0] = mri(6, 0, 'h20); mem[1] = W_CMA; mem[2] = mri(3, 0, 'h22); mem[3] = W_HLT;
      mem['h20] = v;
      run(cyc);
      chk("R7", "ISZ writeback", 32'(mem['h20]), 32'(w));
      chk("R7", "ISZ skip effect", 32'(mem['h22]), (w == 0) ? 32'h0 : 32'hFFFF);
      chk("R7", "ISZ cycles", 32'(cyc), (w == 0) ? 16 : 20);
    end

    // R8 and R9: register operations over seeds and E
    for (int o = 0; o < 7; o++) begin
      for (int k = 0; k < 8; k++) begin
        for (int e0 = 0; e0 < 2; e0++) begin
          logic [15:0] op, s, ea;
          logic ee;
          string rq;
          s = 16'(k * 16'h2493) ^ (k[0] ? 16'h8001 : 16'h0000);
          rq = "R8";
          case (o)
            0: begin op = W_CLA; ea = 16'h0; ee = 1'(e0); end
            1: begin op = W_CLE; ea = s; ee = 1'b0; end
            2: begin op = W_CMA; ea = ~s; ee = 1'(e0); end
            3: begin op = W_CME; ea = s; ee = !1'(e0); end
            4: begin op = W_CIR; ea = {1'(e0), s[15:1]}; ee = s[0]; rq = "R9"; end
            5: begin op = W_CIL; ea = {s[14:0], 1'(e0)}; ee = s[15]; rq = "R9"; end
            default: begin op = W_INC; ea = s + 16'h0001; ee = 1'(e0); end
          endcase
          wipe();
          mem[0] = mri(2, 0, 'h20); mem[1] = W_CLE; mem[2] = e0 ? W_CME : W_CLE;
          mem[3] = op; mem[4] = mri(3, 0, 'h21); mem[5] = W_CLA; mem[6] = W_CIL;
          mem[7] = mri(3, 0, 'h22); mem[8] = W_HLT;
          mem['h20] = s;
          run(cyc);
          chk(rq, "register op AC", 32'(mem['h21]), 32'(ea));
          chk(rq, "register op E", 32'(mem['h22]), 32'(ee));
          chk(rq, "register op cycles", 32'(cyc), 40);
        end
      end
    end

    // R10: conditional skips
    for (int o = 0; o < 4; o++) begin
      for (int k = 0; k < 7; k++) begin
        for (int e0 = 0; e0 < 2; e0++) begin
          logic [15:0] op, s;
          bit sk;
          case (k)
            0: s = 16'h0000; 1: s = 16'h0001; 2: s = 16'h7FFF; 3: s = 16'h8000;
            4: s = 16'hFFFF; 5: s = 16'h1234; default: s = 16'hC000;
          endcase
          case (o)
            0: begin op = W_SPA; sk = !s[15]; end
            1: begin op = W_SNA; sk = s[15]; end
            2: begin op = W_SZA; sk = (s == 16'h0); end
            default: begin op = W_SZE; sk = (e0 == 0); end
          endcase
          wipe();
          mem[0] = mri(2, 0, 'h20); mem[1] = W_CLE; mem[2] = e0 ? W_CME : W_CLE;
          mem[3] = op; mem[4] = mri(3, 0, 'h21); mem[5] = W_HLT;
          mem['h20] = s; mem['h21] = 16'hDEAD;
          run(cyc);
          chk("R10", "skip result", 32'(mem['h21]), sk ? 32'hDEAD : 32'(s));
          chk("R10", "skip cycles", 32'(cyc), sk ? 22 : 27);
        end
      end
    end

    // R12: combined register bits, highest wins
    wipe();
    mem[0] = mri(2, 0, 'h20); mem[1] = 16'h7820; mem[2] = mri(3, 0, 'h21);
    mem[3] = 16'h7021; mem[4] = mri(3, 0, 'h22); mem[5] = W_HLT;
    mem['h20] = 16'h0005;
    run(cyc);
    chk("R12", "clear beats increment", 32'(mem['h21]), 0);
    chk("R12", "increment beats halt", 32'(mem['h22]), 1);
    chk("R12", "combined cycles", 32'(cyc), 28);

    // R13: I/O-space words have no effect
    wipe();
    mem[0] = mri(2, 0, 'h20); mem[1] = 16'hF800; mem[2] = 16'hF200;
    mem[3] = mri(3, 0, 'h21); mem[4] = W_HLT;
    mem['h20] = 16'h5A3C;
    run(cyc);
    chk("R13", "AC unchanged", 32'(mem['h21]), 32'h5A3C);
    chk("R13", "I/O word cycles", 32'(cyc), 23);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule